// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Transmitter

This block is a transmit-only serial master for the control port of a display controller. The control port takes 9-bit words. Bit 8 of each word tells the controller whether the word is a command or a parameter. Bits 7:0 carry the byte. A client hands over one request at a time on a valid/ready handshake. The block turns the request into a frame of one, two or three words and shifts the frame out on a serial clock, a data line and an active-low select.

A request holds a command byte, a length code and a 16-bit parameter field. The length code selects one of three frames: a command alone, a command followed by one parameter byte, or a command followed by a 16-bit value split into two parameter words. The controller has no return line, so nothing is ever sampled from the bus.

The bus runs with the clock idling high. Data changes on the falling clock edge and is sampled by the controller on the rising edge. The serial clock is the system clock divided by an even ratio set by a parameter. While a frame is on the wire the block shows busy. Once select has been released and the inter-frame gap has passed, it raises a one-cycle done pulse.

Top module: `panel_cmd_tx`

## Requirements
- R1: After reset, csN is 1, sclk is 1, busy is 0, done is 0 and reqReady is 1.
- R2: sclk is high whenever csN is high. Inside a frame, each low phase and each high phase of sclk lasts CLK_DIV/2 system clock cycles, and the first falling edge comes CLK_DIV/2 cycles after csN falls.
- R3: mosi changes only while sclk is low and holds steady through every high phase. Each word is 9 bits, sent most significant bit first, so bit 8 is the first bit on the wire.
- R4: The first word of every frame is {1'b0, reqCmd}: bit 8 is 0 and bits 7:0 are the command byte.
- R5: With reqLen = 1, the frame has two words. The second word is {1'b1, reqParam[7:0]}.
- R6: With reqLen = 2, the frame has three words. These are {1'b1, reqParam[15:8]} and then {1'b1, reqParam[7:0]}, high byte first.
- R7: With reqLen = 0, the frame holds only the command word. The code reqLen = 3 is reserved and sends the same three-word frame as reqLen = 2.
- R8: All words of one request are sent inside a single low period of csN. Between frames, csN stays high for at least CLK_DIV system clock cycles.
- R9: done is a pulse exactly one cycle wide. It comes once per frame, only while csN is high, after select has been released.
- R10: A request is taken only in a cycle where reqValid and reqReady are both 1. reqReady is 0 while busy. A reqValid asserted during a busy frame has no effect: it starts no frame and does not change the words of the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and able to take a request |
| reqCmd | input | 8 | Command byte |
| reqLen | input | 2 | Parameter byte count: 0, 1, 2 (3 acts as 2) |
| reqParam | input | 16 | Parameter value; low byte used when reqLen is 1 |
| busy | output | 1 | Frame in progress, including the trailing gap |
| done | output | 1 | One-cycle pulse at frame completion |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Active-low select |

## Verification
The properties assume that reset is held low from time zero through at least one clock edge. They also assume that request fields are stable in the cycle where reqValid meets reqReady, since the fields are captured only in that cycle.

The bench drives every input on the falling system clock edge and keeps reqValid high until it has seen reqReady. This means a handshake always completes on a clean rising edge. The bench raises reqValid during a busy frame only in the test built for that purpose, and it drops reqValid there before the block returns to idle, so the stray request is never accepted.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int WORD_W = 9;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  localparam int MAX_WORDS = 3;

  // control-to-datapath strobes
  typedef struct packed {
    logic             load;     // capture request fields into frame words
    logic             csOn;     // drive select low
    logic             csOff;    // release select
    logic             fall;     // drive sclk low and present next bit
    logic             rise;     // drive sclk high
    logic             newWord;  // next bit comes from a fresh frame word
    logic [SEL_W-1:0] wordSel;  // which frame word to start
  } ptxStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_LOW,
    S_HIGH,
    S_GAP
  } ptxState_t;
endpackage

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
  import ptx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [1:0] reqLen,
  output logic       reqReady,
  output logic       busy,
  output logic       done,
  output ptxStrobe_t stb
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int PH_W  = $clog2(CLK_DIV) + 1;
  localparam int BIT_W = $clog2(WORD_W);

  ptxState_t        state;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitIdx;
  logic [SEL_W-1:0] wordIdx;
  logic [SEL_W-1:0] lastWord;
  logic             doneR;

  logic halfEnd, gapEnd, bitLast, wordLast;

  assign halfEnd  = (phase == PH_W'(HALF - 1));
  assign gapEnd   = (phase == PH_W'(CLK_DIV - 1));
  assign bitLast  = (bitIdx == BIT_W'(WORD_W - 1));
  assign wordLast = (wordIdx == lastWord);

  function automatic logic [SEL_W-1:0] lenToLast(input logic [1:0] len);
    case (len)
      2'd0:    return SEL_W'(0);
      2'd1:    return SEL_W'(1);
      default: return SEL_W'(MAX_WORDS - 1);
    endcase
  endfunction

  always_comb begin
    stb = '0;
    stb.wordSel = wordIdx;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.load = 1'b1;
          stb.csOn = 1'b1;
        end
      end
      S_LEAD: begin
        if (halfEnd) begin
          stb.fall    = 1'b1;
          stb.newWord = 1'b1;
          stb.wordSel = '0;
        end
      end
      S_LOW: begin
        if (halfEnd) stb.rise = 1'b1;
      end
      S_HIGH: begin
        if (halfEnd) begin
          if (bitLast && wordLast) begin
            stb.csOff = 1'b1;
          end else if (bitLast) begin
            stb.fall    = 1'b1;
            stb.newWord = 1'b1;
            stb.wordSel = wordIdx + SEL_W'(1);
          end else begin
            stb.fall = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= '0;
      bitIdx   <= '0;
      wordIdx  <= '0;
      lastWord <= '0;
      doneR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        S_IDLE: begin
          if (reqValid) begin
            state    <= S_LEAD;
            phase    <= '0;
            bitIdx   <= '0;
            wordIdx  <= '0;
            lastWord <= lenToLast(reqLen);
          end
        end
        S_LEAD: begin
          if (halfEnd) begin
            state <= S_LOW;
            phase <= '0;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        S_LOW: begin
          if (halfEnd) begin
            state <= S_HIGH;
            phase <= '0;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        S_HIGH: begin
          if (halfEnd) begin
            phase <= '0;
            if (bitLast) begin
              bitIdx <= '0;
              if (wordLast) begin
                state <= S_GAP;
              end else begin
                wordIdx <= wordIdx + SEL_W'(1);
                state   <= S_LOW;
              end
            end else begin
              bitIdx <= bitIdx + BIT_W'(1);
              state  <= S_LOW;
            end
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        S_GAP: begin
          if (gapEnd) begin
            state <= S_IDLE;
            phase <= '0;
            doneR <= 1'b1;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);
  assign done     = doneR;
endmodule

// File: rtl/ptx_datapath.sv
module ptx_datapath
  import ptx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ptxStrobe_t        stb,
  input  logic [BYTE_W-1:0] reqCmd,
  input  logic [1:0]        reqLen,
  input  logic [15:0]       reqParam,
  output logic              sclk,
  output logic              mosi,
  output logic              csN
);
  logic [WORD_W-1:0] frameW [MAX_WORDS];
  logic [WORD_W-1:0] nextW  [MAX_WORDS];
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] src;
  logic              sclkR, mosiR, csNR;

  // word images: flag bit on top, payload below
  always_comb begin
    nextW[0] = {1'b0, reqCmd};
    nextW[1] = {1'b1, (reqLen == 2'd1) ? reqParam[BYTE_W-1:0]
                                       : reqParam[2*BYTE_W-1:BYTE_W]};
    nextW[2] = {1'b1, reqParam[BYTE_W-1:0]};
  end

  for (genvar gi = 0; gi < MAX_WORDS; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frameW[gi] <= '0;
      else if (stb.load) frameW[gi] <= nextW[gi];
    end
  end

  always_comb begin
    if (stb.newWord) begin
      case (stb.wordSel)
        SEL_W'(0): src = frameW[0];
        SEL_W'(1): src = frameW[1];
        default:   src = frameW[2];
      endcase
    end else begin
      src = shreg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sclkR <= 1'b1;
      mosiR <= 1'b1;
      csNR  <= 1'b1;
    end else begin
      if (stb.csOn)  csNR <= 1'b0;
      if (stb.csOff) csNR <= 1'b1;
      if (stb.fall) begin
        sclkR <= 1'b0;
        mosiR <= src[WORD_W-1];
        shreg <= {src[WORD_W-2:0], 1'b0};
      end
      if (stb.rise) sclkR <= 1'b1;
    end
  end

  assign sclk = sclkR;
  assign mosi = mosiR;
  assign csN  = csNR;
endmodule

// File: rtl/panel_cmd_tx.sv
module panel_cmd_tx
  import ptx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [7:0]  reqCmd,
  input  logic [1:0]  reqLen,
  input  logic [15:0] reqParam,
  output logic        busy,
  output logic        done,
  output logic        sclk,
  output logic        mosi,
  output logic        csN
);
  ptxStrobe_t stb;

  ptx_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqLen   (reqLen),
    .reqReady (reqReady),
    .busy     (busy),
    .done     (done),
    .stb      (stb)
  );

  ptx_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .reqCmd   (reqCmd),
    .reqLen   (reqLen),
    .reqParam (reqParam),
    .sclk     (sclk),
    .mosi     (mosi),
    .csN      (csN)
  );
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker (
  input logic clk,
  input logic rst_n,
  input logic reqValid,
  input logic reqReady,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic csN
);
  // R2: clock rests high outside a frame
  a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> sclk);

  // R3: data line steady across a high phase inside a frame
  a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && !$past(csN) && sclk && $past(sclk)) |-> $stable(mosi));

  // R9: done only while select is released
  a_r9_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> csN);

  // R9: done never longer than one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: accepted request makes the block busy
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> busy);

  // R10: no acceptance while busy
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !reqReady);

  // R8: select falls only with the clock high
  a_r8_cs_fall_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csN) |-> sclk);
endmodule

bind panel_cmd_tx ptx_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .busy     (busy),
  .done     (done),
  .sclk     (sclk),
  .mosi     (mosi),
  .csN      (csN)
);

// File: tb/tb_panel_cmd_tx.sv
module tb_panel_cmd_tx;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int HALF_NS    = CLK_PERIOD * CLK_DIV / 2;
  localparam int NVEC       = 8;

  // {cmd, len, param, expected word count}
  localparam logic [27:0] VEC [NVEC] = '{
    {8'h29, 2'd0, 16'h0000, 2'd1},
    {8'hB0, 2'd1, 16'h0017, 2'd2},
    {8'hC3, 2'd2, 16'h2040, 2'd3},
    {8'h00, 2'd0, 16'hFFFF, 2'd1},
    {8'hFF, 2'd1, 16'hA5C3, 2'd2},
    {8'h55, 2'd2, 16'hFF00, 2'd3},
    {8'hAA, 2'd3, 16'h1234, 2'd3},
    {8'h81, 2'd2, 16'h01FE, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqCmd = '0;
  logic [1:0]  reqLen = '0;
  logic [15:0] reqParam = '0;
  logic        busy, done, sclk, mosi, csN;

  int nChecks = 0;
  int nFail   = 0;

  panel_cmd_tx #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqLen(reqLen), .reqParam(reqParam),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .csN(csN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---- serial receiver model ----
  logic [8:0] shiftIn = '0;
  logic [8:0] capW [8];
  int  bitCount = 0;
  int  capN = 0;
  int  framesSeen = 0;
  int  doneSeen = 0;
  int  phaseErr = 0;
  int  gapErr = 0;
  int  gapsMeasured = 0;
  time tLast = 0;
  time tCsRise = 0;
  bit  haveRise = 1'b0;

  always @(negedge csN) begin
    bitCount = 0;
    capN = 0;
    tLast = $time;
    if (haveRise) begin
      gapsMeasured++;
      if (($time - tCsRise) < time'(CLK_DIV * CLK_PERIOD)) gapErr++;
    end
  end

  always @(posedge csN) begin
    if (rst_n) begin
      framesSeen++;
      tCsRise = $time;
      haveRise = 1'b1;
    end
  end

  always @(negedge sclk) begin
    if (!csN && (($time - tLast) != time'(HALF_NS))) phaseErr++;
    tLast = $time;
  end

  always @(posedge sclk) begin
    if (!csN) begin
      if (($time - tLast) != time'(HALF_NS)) phaseErr++;
      tLast = $time;
      shiftIn = {shiftIn[7:0], mosi};
      bitCount++;
      if (bitCount % 9 == 0) begin
        if (capN < 8) capW[capN] = shiftIn;
        capN++;
      end
    end
  end

  always @(negedge clk) if (rst_n && done) doneSeen++;

  // ---- helpers ----
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] expWord(input logic [7:0] cmd,
                                         input logic [1:0] len,
                                         input logic [15:0] prm,
                                         input int idx);
    if (idx == 0) return {1'b0, cmd};
    if (idx == 1) return (len == 2'd1) ? {1'b1, prm[7:0]} : {1'b1, prm[15:8]};
    return {1'b1, prm[7:0]};
  endfunction

  function automatic string lenTag(input logic [1:0] len);
    case (len)
      2'd0: return "R7";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic issue(input logic [7:0] c, input logic [1:0] l,
                       input logic [15:0] p);
    @(negedge clk);
    reqCmd = c; reqLen = l; reqParam = p; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runFrame(input logic [7:0] c, input logic [1:0] l,
                          input logic [15:0] p, input int expN);
    int f0, d0;
    f0 = framesSeen; d0 = doneSeen; phaseErr = 0;
    issue(c, l, p);
    waitDone();
    chk(capN == expN, lenTag(l), "word count", capN, expN);
    chk(bitCount == 9 * expN, "R3", "bit count", bitCount, 9 * expN);
    for (int i = 0; i < expN && i < 3; i++) begin
      logic [8:0] e;
      e = expWord(c, l, p, i);
      if (i == 0) chk(capW[i] == e, "R4", "command word", capW[i], e);
      else        chk(capW[i] == e, lenTag(l), "data word", capW[i], e);
    end
    chk(phaseErr == 0, "R2", "sclk phase width errors", phaseErr, 0);
    chk(framesSeen - f0 == 1, "R8", "select periods per request", framesSeen - f0, 1);
    chk(doneSeen - d0 == 1, "R9", "done pulses per request", doneSeen - d0, 1);
  endtask

  // ---- watchdog ----
  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFail++;
    $display("FAIL R9 watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  // ---- main sequence ----
  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b1, "R1", "select/clock in reset", {csN, sclk}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    chk(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);

    // table walk, back to back
    for (int v = 0; v < NVEC; v++) begin
      runFrame(VEC[v][27:20], VEC[v][19:18], VEC[v][17:2], int'(VEC[v][1:0]));
    end
    chk(gapsMeasured > 0 && gapErr == 0, "R8", "inter-frame gap violations",
        gapErr, 0);

    // R10: valid while busy is ignored
    begin
      int f0;
      f0 = framesSeen;
      issue(8'h3C, 2'd2, 16'hBEEF);
      repeat (10) @(negedge clk);
      chk(busy == 1'b1 && reqReady == 1'b0, "R10", "ready while busy",
          reqReady, 0);
      reqCmd = 8'h11; reqLen = 2'd0; reqParam = 16'h0000; reqValid = 1'b1;
      repeat (20) @(negedge clk);
      reqValid = 1'b0;
      waitDone();
      repeat (3 * CLK_DIV) @(negedge clk);
      chk(framesSeen - f0 == 1, "R10", "frames after stray valid",
          framesSeen - f0, 1);
      chk(capW[0] == 9'h03C && capW[1] == 9'h1BE && capW[2] == 9'h1EF, "R10",
          "in-flight words", capW[0], 9'h03C);
      chk(busy == 1'b0 && csN == 1'b1, "R10", "idle after stray valid",
          {busy, csN}, 2'b01);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule